// File: doc/BRIEF.md
# Shadowed Shift Slice Chain

This block is a bank of shift slices for streaming parallel data between an 8-bit pin port and a host. Each slice holds a 32-bit working word, a 32-bit shadow word, and a down-counter that counts shifts. Each slice shifts either one bit or one byte per qualified edge of an external clock pin. When the count runs out, the working word and the shadow word trade places. The host can then collect a full word, or supply the next one, while shifting goes on. On each such exchange a sticky per-slice flag is raised for the host.

The external clock, qualifier and data pins all pass through the same synchronizer chain in the system clock domain, so they stay aligned with each other. A slice advances only when three conditions hold:
- its bit in the global enable mask is set;
- the selected edge of the synchronized external clock occurs;
- the qualifier, after an optional per-slice inversion, is high.

The input of a slice can come from the pins, from its own low end (recirculation), or from the low end of the slice before it. The slices form a ring, so eight byte-wide slices can act as one long 256-bit path. A slice in 1-bit recirculation mode that is loaded with a repeating pattern produces a periodic pulse on its bit output.

Top module: `shadow_shift_chain`

## Requirements
- R1: After reset, every working word, shadow word, configuration, reload value, the enable mask, all exchange flags, `dout_o` and `slice_bit_o` are zero.
- R2: Host address `4*s+f` reaches slice `s` field `f`. The fields are: f=0 configuration (bit0 byte mode, bits 2:1 input source with 0 = pins, 1 = self-recirculation, 2 = previous slice; bit3 qualifier inversion; bit4 falling-edge select; other bits read 0); f=1 working word; f=2 shadow word; f=3 reload value (5 bits; a write also loads the counter). Address `4*NUM_SLICES` holds the enable mask, and address `4*NUM_SLICES+1` reads the exchange flags. A read returns what was written, limited to the field width.
- R3: A slice whose enable mask bit is clear never changes its working or shadow word on clock-pin edges.
- R4: A slice shifts only when the synchronized qualifier XOR its inversion bit is 1.
- R5: With bit4 clear, a slice shifts on a rising edge of the clock pin and not on a falling one. With bit4 set, it shifts on a falling edge and not on a rising one.
- R6: In byte mode, a shift moves the working word down 8 bits and puts the input byte in bits 31:24. `dout_o` is the low byte of slice 0's working word.
- R7: In bit mode, a shift moves the working word down 1 bit and puts input bit 0 in bit 31. `slice_bit_o[s]` is bit 0 of slice `s`'s working word.
- R8: The input source is one of three: the data pins; the slice's own low byte or low bit; or the low byte or bit of slice `s-1`, where slice 0's predecessor is the last slice.
- R9: A shift taken while the counter is 0 moves the old shadow word into the working word, puts the shifted word in the shadow, and reloads the counter. Any other shift decrements the counter.
- R10: An exchange sets the slice's flag, and the flag stays set. Writing 1 to a flag bit at address `4*NUM_SLICES+1` clears it. Writing 0 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_clk_i | input | 1 | External shift clock pin |
| ext_qual_i | input | 1 | External qualifier pin |
| ext_din_i | input | PORT_W | External data pins |
| host_wr_i | input | 1 | Host write strobe |
| host_addr_i | input | ADDR_W | Host write address |
| host_wdata_i | input | DATA_W | Host write data |
| host_raddr_i | input | ADDR_W | Host read address |
| host_rdata_o | output | DATA_W | Host read data, combinational from the read address |
| dout_o | output | PORT_W | Low byte of slice 0 working word |
| slice_bit_o | output | NUM_SLICES | Bit 0 of each slice working word |
| xchg_flag_o | output | NUM_SLICES | Sticky exchange flags |

## Verification
On every cycle the assertions check four things:
- a disabled or unqualified slice holds its words;
- the counter never exceeds its reload value;
- an exchange puts the old shadow word into the working word and raises the flag;
- a detected clock edge lasts exactly one cycle.

Other properties depend on arithmetic over many shifts, so only the bench scenarios show them:
- the exact byte and bit positions after a run of shifts;
- the ring order of a full eight-slice chain after 31 and 32 byte shifts;
- the period of a recirculated pattern;
- rising versus falling edge selection;
- the write-one-to-clear behaviour of the flags.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

    typedef enum logic [1:0] {
        SRC_PINS = 2'd0,
        SRC_LOOP = 2'd1,
        SRC_PREV = 2'd2,
        SRC_RSVD = 2'd3
    } src_sel_e;

    typedef struct packed {
        logic     fall_edge;
        logic     qual_inv;
        src_sel_e src;
        logic     byte_mode;
    } slice_cfg_t;

    localparam int CFG_W = $bits(slice_cfg_t);

    localparam logic [1:0] FLD_CFG = 2'd0;
    localparam logic [1:0] FLD_PRI = 2'd1;
    localparam logic [1:0] FLD_SHD = 2'd2;
    localparam logic [1:0] FLD_POS = 2'd3;

    localparam int FIELDS_PER_SLICE = 4;

endpackage

// File: rtl/ssc_pin_sync.sv
module ssc_pin_sync #(
    parameter int PORT_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_clk_i,
    input  logic              ext_qual_i,
    input  logic [PORT_W-1:0] ext_din_i,
    output logic              rise_o,
    output logic              fall_o,
    output logic              qual_o,
    output logic [PORT_W-1:0] din_o
);
    localparam int W = PORT_W + 2;

    logic [W-1:0] stg_q [SYNC_STAGES];
    logic         clk_prev_q;
    logic [W-1:0] last;

    assign last = stg_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SYNC_STAGES; i++) stg_q[i] <= '0;
            clk_prev_q <= 1'b0;
        end else begin
            stg_q[0] <= {ext_clk_i, ext_qual_i, ext_din_i};
            for (int i = 1; i < SYNC_STAGES; i++) stg_q[i] <= stg_q[i-1];
            clk_prev_q <= last[W-1];
        end
    end

    assign rise_o = last[W-1] & ~clk_prev_q;
    assign fall_o = ~last[W-1] & clk_prev_q;
    assign qual_o = last[W-2];
    assign din_o  = last[PORT_W-1:0];

    // R5: a detected edge is a single-cycle event
    a_r5_edge_single: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o);

endmodule

// File: rtl/ssc_slice.sv
module ssc_slice
    import ssc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int PORT_W = 8,
    parameter int POS_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_i,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic              qual_i,
    input  logic [PORT_W-1:0] pin_din_i,
    input  logic [PORT_W-1:0] prev_byte_i,
    input  logic              wr_i,
    input  logic [1:0]        wr_field_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              clr_flag_i,
    output logic [PORT_W-1:0] out_byte_o,
    output slice_cfg_t        cfg_o,
    output logic [DATA_W-1:0] pri_o,
    output logic [DATA_W-1:0] shd_o,
    output logic [POS_W-1:0]  reload_o,
    output logic              flag_o
);
    slice_cfg_t        cfg_q;
    logic [DATA_W-1:0] pri_q, shd_q, shifted;
    logic [POS_W-1:0]  reload_q, cnt_q;
    logic              flag_q;
    logic [PORT_W-1:0] in_byte;
    logic              edge_hit, qual_ok, shift_go, xchg;

    always_comb begin
        unique case (cfg_q.src)
            SRC_LOOP: in_byte = pri_q[PORT_W-1:0];
            SRC_PREV: in_byte = prev_byte_i;
            default:  in_byte = pin_din_i;
        endcase
        shifted  = cfg_q.byte_mode ? {in_byte, pri_q[DATA_W-1:PORT_W]}
                                   : {in_byte[0], pri_q[DATA_W-1:1]};
        edge_hit = cfg_q.fall_edge ? fall_i : rise_i;
        qual_ok  = qual_i ^ cfg_q.qual_inv;
        shift_go = en_i & edge_hit & qual_ok & ~wr_i;
        xchg     = shift_go & (cnt_q == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= '0;
            pri_q    <= '0;
            shd_q    <= '0;
            reload_q <= '0;
            cnt_q    <= '0;
        end else if (wr_i) begin
            unique case (wr_field_i)
                FLD_CFG: cfg_q <= slice_cfg_t'(wr_data_i[CFG_W-1:0]);
                FLD_PRI: pri_q <= wr_data_i;
                FLD_SHD: shd_q <= wr_data_i;
                default: begin
                    reload_q <= wr_data_i[POS_W-1:0];
                    cnt_q    <= wr_data_i[POS_W-1:0];
                end
            endcase
        end else if (shift_go) begin
            if (xchg) begin
                pri_q <= shd_q;
                shd_q <= shifted;
                cnt_q <= reload_q;
            end else begin
                pri_q <= shifted;
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)             flag_q <= 1'b0;
        else if (xchg)       flag_q <= 1'b1;
        else if (clr_flag_i) flag_q <= 1'b0;
    end

    assign out_byte_o = cfg_q.byte_mode ? pri_q[PORT_W-1:0]
                                        : {{(PORT_W-1){1'b0}}, pri_q[0]};
    assign cfg_o      = cfg_q;
    assign pri_o      = pri_q;
    assign shd_o      = shd_q;
    assign reload_o   = reload_q;
    assign flag_o     = flag_q;

    a_r3_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (!en_i && !wr_i) |=> ($stable(pri_q) && $stable(shd_q)));

    a_r4_unqualified_holds: assert property (@(posedge clk) disable iff (rst)
        (!wr_i && (qual_i == cfg_q.qual_inv)) |=> $stable(pri_q));

    a_r9_count_bounded: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= reload_q);

    a_r9_swap_in_shadow: assert property (@(posedge clk) disable iff (rst)
        xchg |=> (pri_q == $past(shd_q)));

    a_r10_flag_raised: assert property (@(posedge clk) disable iff (rst)
        xchg |=> flag_q);

endmodule

// File: rtl/shadow_shift_chain.sv
module shadow_shift_chain
    import ssc_pkg::*;
#(
    parameter int NUM_SLICES  = 8,
    parameter int DATA_W      = 32,
    parameter int PORT_W      = 8,
    parameter int POS_W       = 5,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = $clog2(NUM_SLICES * FIELDS_PER_SLICE + 2)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ext_clk_i,
    input  logic                  ext_qual_i,
    input  logic [PORT_W-1:0]     ext_din_i,
    input  logic                  host_wr_i,
    input  logic [ADDR_W-1:0]     host_addr_i,
    input  logic [DATA_W-1:0]     host_wdata_i,
    input  logic [ADDR_W-1:0]     host_raddr_i,
    output logic [DATA_W-1:0]     host_rdata_o,
    output logic [PORT_W-1:0]     dout_o,
    output logic [NUM_SLICES-1:0] slice_bit_o,
    output logic [NUM_SLICES-1:0] xchg_flag_o
);
    localparam int              IDX_W  = $clog2(NUM_SLICES);
    localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(NUM_SLICES * FIELDS_PER_SLICE);
    localparam logic [ADDR_W-1:0] FLAG_A = ADDR_W'(NUM_SLICES * FIELDS_PER_SLICE + 1);

    logic              rise, fall, qual;
    logic [PORT_W-1:0] din;
    logic [NUM_SLICES-1:0] mask_q, clr_vec, flags;
    logic [PORT_W-1:0] out_a    [NUM_SLICES];
    slice_cfg_t        cfg_a    [NUM_SLICES];
    logic [DATA_W-1:0] pri_a    [NUM_SLICES];
    logic [DATA_W-1:0] shd_a    [NUM_SLICES];
    logic [POS_W-1:0]  reload_a [NUM_SLICES];

    ssc_pin_sync #(.PORT_W(PORT_W), .SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst),
        .ext_clk_i(ext_clk_i), .ext_qual_i(ext_qual_i), .ext_din_i(ext_din_i),
        .rise_o(rise), .fall_o(fall), .qual_o(qual), .din_o(din)
    );

    always_ff @(posedge clk) begin
        if (rst)                                    mask_q <= '0;
        else if (host_wr_i && host_addr_i == MASK_A) mask_q <= host_wdata_i[NUM_SLICES-1:0];
    end

    assign clr_vec = (host_wr_i && host_addr_i == FLAG_A) ? host_wdata_i[NUM_SLICES-1:0] : '0;

    for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
        logic slice_wr;
        assign slice_wr = host_wr_i && (host_addr_i < MASK_A)
                          && (int'(host_addr_i[ADDR_W-1:2]) == s);

        ssc_slice #(.DATA_W(DATA_W), .PORT_W(PORT_W), .POS_W(POS_W)) u_slice (
            .clk(clk), .rst(rst),
            .en_i(mask_q[s]), .rise_i(rise), .fall_i(fall), .qual_i(qual),
            .pin_din_i(din),
            .prev_byte_i(out_a[(s + NUM_SLICES - 1) % NUM_SLICES]),
            .wr_i(slice_wr), .wr_field_i(host_addr_i[1:0]), .wr_data_i(host_wdata_i),
            .clr_flag_i(clr_vec[s]),
            .out_byte_o(out_a[s]), .cfg_o(cfg_a[s]), .pri_o(pri_a[s]),
            .shd_o(shd_a[s]), .reload_o(reload_a[s]), .flag_o(flags[s])
        );

        assign slice_bit_o[s] = pri_a[s][0];
    end

    always_comb begin
        logic [IDX_W-1:0] idx;
        idx          = host_raddr_i[IDX_W+1:2];
        host_rdata_o = '0;
        if (host_raddr_i == MASK_A) begin
            host_rdata_o[NUM_SLICES-1:0] = mask_q;
        end else if (host_raddr_i == FLAG_A) begin
            host_rdata_o[NUM_SLICES-1:0] = flags;
        end else if (host_raddr_i < MASK_A) begin
            unique case (host_raddr_i[1:0])
                FLD_CFG: host_rdata_o[CFG_W-1:0] = cfg_a[idx];
                FLD_PRI: host_rdata_o            = pri_a[idx];
                FLD_SHD: host_rdata_o            = shd_a[idx];
                default: host_rdata_o[POS_W-1:0] = reload_a[idx];
            endcase
        end
    end

    assign dout_o      = pri_a[0][PORT_W-1:0];
    assign xchg_flag_o = flags;

endmodule

// File: tb/shadow_shift_chain_bench.sv
`timescale 1ns/1ps
module shadow_shift_chain_bench;
    localparam int NS = 8;
    localparam int AW = 6;
    localparam int MASK_ADDR = NS * 4;
    localparam int FLAG_ADDR = NS * 4 + 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ext_clk = 1'b0, ext_qual = 1'b0;
    logic [7:0]    ext_din = '0;
    logic          host_wr = 1'b0;
    logic [AW-1:0] host_addr = '0, host_raddr = '0;
    logic [31:0]   host_wdata = '0, host_rdata;
    logic [7:0]    dout;
    logic [NS-1:0] slice_bit, xflag;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    shadow_shift_chain u_shadow_shift_chain (
        .clk(clk), .rst(rst),
        .ext_clk_i(ext_clk), .ext_qual_i(ext_qual), .ext_din_i(ext_din),
        .host_wr_i(host_wr), .host_addr_i(host_addr), .host_wdata_i(host_wdata),
        .host_raddr_i(host_raddr), .host_rdata_o(host_rdata),
        .dout_o(dout), .slice_bit_o(slice_bit), .xchg_flag_o(xflag)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [31:0] data);
        @(negedge clk);
        host_wr = 1'b1; host_addr = AW'(addr); host_wdata = data;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input int addr, output logic [31:0] data);
        @(negedge clk);
        host_raddr = AW'(addr);
        #1 data = host_rdata;
    endtask

    task automatic half(input logic level);
        @(negedge clk);
        ext_clk = level;
        repeat (5) @(negedge clk);
    endtask

    task automatic pulse(input logic [7:0] b, input logic q);
        @(negedge clk);
        ext_din = b; ext_qual = q;
        half(1'b1);
        half(1'b0);
    endtask

    function automatic logic [31:0] chain_exp(input int j, input int n);
        logic [31:0] w;
        w = '0;
        for (int k = 0; k < 4; k++) begin
            int p;
            p = 4 * j + 3 - k;
            if (p < n) w[8*k +: 8] = 8'(8'hA0 + (n - 1 - p));
        end
        return w;
    endfunction

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v, exp_pri, exp_shd;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(1, v);         check("R1 pri0", v, 32'h0);
        rd(MASK_ADDR, v); check("R1 mask", v, 32'h0);
        rd(FLAG_ADDR, v); check("R1 flags", v, 32'h0);
        check("R1 dout", {24'h0, dout}, 32'h0);
        check("R1 slice_bit", {24'h0, slice_bit}, 32'h0);

        // R2 address map and field widths
        wr(3*4+0, 32'h0000_001F); rd(3*4+0, v); check("R2 cfg", v, 32'h1F);
        wr(3*4+0, 32'hFFFF_FFFF); rd(3*4+0, v); check("R2 cfg width", v, 32'h1F);
        wr(3*4+3, 32'h0000_003F); rd(3*4+3, v); check("R2 reload width", v, 32'h1F);
        wr(3*4+2, 32'hDEAD_BEEF); rd(3*4+2, v); check("R2 shadow", v, 32'hDEAD_BEEF);
        wr(MASK_ADDR, 32'hFF);    rd(MASK_ADDR, v); check("R2 mask", v, 32'hFF);
        wr(MASK_ADDR, 32'h0);

        // R3 disabled slice ignores edges
        wr(0, 32'h01);
        wr(1, 32'h1234_5678);
        wr(2, 32'hCAFE_F00D);
        wr(3, 32'h3);
        pulse(8'hAA, 1'b1);
        rd(1, v); check("R3 disabled pri", v, 32'h1234_5678);
        rd(2, v); check("R3 disabled shd", v, 32'hCAFE_F00D);

        // R4 qualifier low blocks shift
        wr(MASK_ADDR, 32'h01);
        pulse(8'h55, 1'b0);
        rd(1, v); check("R4 qual low", v, 32'h1234_5678);

        // R6 R9 R10 byte shifts with exchange on fourth
        exp_pri = 32'h1234_5678;
        exp_shd = 32'hCAFE_F00D;
        for (int k = 0; k < 4; k++) begin
            logic [7:0] b;
            b = 8'(8'h31 + 8'h11 * k);
            pulse(b, 1'b1);
            if (k < 3) begin
                exp_pri = {b, exp_pri[31:8]};
                rd(1, v); check("R6 byte shift", v, exp_pri);
                check("R6 dout", {24'h0, dout}, {24'h0, exp_pri[7:0]});
                check("R10 flag quiet", {31'h0, xflag[0]}, 32'h0);
            end else begin
                logic [31:0] sh;
                sh = {b, exp_pri[31:8]};
                rd(1, v); check("R9 pri takes shadow", v, exp_shd);
                rd(2, v); check("R9 shadow takes word", v, sh);
                check("R10 flag set", {31'h0, xflag[0]}, 32'h1);
                check("R6 dout after swap", {24'h0, dout}, 32'h0D);
                exp_pri = exp_shd;
                exp_shd = sh;
            end
        end
        wr(FLAG_ADDR, 32'h0); rd(FLAG_ADDR, v); check("R10 write0 keeps", v, 32'h1);
        wr(FLAG_ADDR, 32'h1); rd(FLAG_ADDR, v); check("R10 write1 clears", v, 32'h0);
        // R9 counter reloaded: next exchange after four more shifts
        for (int k = 0; k < 4; k++) begin
            pulse(8'h77, 1'b1);
            check("R9 reload period", {31'h0, xflag[0]}, (k == 3) ? 32'h1 : 32'h0);
        end
        wr(FLAG_ADDR, 32'hFF);

        // R4 inverted qualifier
        wr(0, 32'h09);
        wr(1, 32'h0);
        wr(3, 32'h1F);
        pulse(8'hE1, 1'b1);
        rd(1, v); check("R4 inv qual high blocks", v, 32'h0);
        pulse(8'hE2, 1'b0);
        rd(1, v); check("R4 inv qual low shifts", v, 32'hE200_0000);

        // R5 edge selection
        wr(0, 32'h01);
        @(negedge clk); ext_din = 8'hB1; ext_qual = 1'b1;
        half(1'b1);
        rd(1, v); check("R5 rise shifts", v, 32'hB1E2_0000);
        half(1'b0);
        rd(1, v); check("R5 fall ignored in rise mode", v, 32'hB1E2_0000);
        wr(0, 32'h11);
        @(negedge clk); ext_din = 8'hB2;
        half(1'b1);
        rd(1, v); check("R5 rise ignored in fall mode", v, 32'hB1E2_0000);
        half(1'b0);
        rd(1, v); check("R5 fall shifts", v, 32'hB2B1_E200);

        // R7 R8 bit-mode recirculating pattern on slice 1
        wr(MASK_ADDR, 32'h0);
        wr(4+0, 32'h02);
        wr(4+1, 32'h1111_1111);
        wr(4+3, 32'h1F);
        wr(MASK_ADDR, 32'h02);
        exp_pri = 32'h1111_1111;
        for (int k = 0; k < 8; k++) begin
            pulse(8'h00, 1'b1);
            exp_pri = {exp_pri[0], exp_pri[31:1]};
            check("R7 slice_bit pattern", {31'h0, slice_bit[1]}, {31'h0, exp_pri[0]});
        end
        rd(4+1, v); check("R8 loop word", v, exp_pri);

        // R8 eight-slice ring in byte mode
        wr(MASK_ADDR, 32'h0);
        for (int s = 0; s < NS; s++) begin
            wr(4*s+0, (s == 0) ? 32'h01 : 32'h05);
            wr(4*s+1, 32'h0);
            wr(4*s+2, 32'h0);
            wr(4*s+3, 32'h1F);
        end
        wr(FLAG_ADDR, 32'hFF);
        wr(MASK_ADDR, 32'hFF);
        for (int i = 0; i < 31; i++) pulse(8'(8'hA0 + i), 1'b1);
        for (int s = 0; s < NS; s++) begin
            rd(4*s+1, v); check("R8 chain word", v, chain_exp(s, 31));
        end
        check("R10 chain flags quiet", {24'h0, xflag}, 32'h0);
        pulse(8'hA0 + 8'd31, 1'b1);
        check("R9 chain all exchange", {24'h0, xflag}, 32'hFF);
        rd(0*4+2, v); check("R9 chain shadow0", v, 32'hBFBE_BDBC);
        rd(7*4+2, v); check("R9 chain shadow7", v, 32'hA3A2_A1A0);
        rd(0*4+1, v); check("R9 chain pri0", v, 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule